// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block collects fifteen interrupt request lines and chooses which one the CPU should take next. Each source belongs to one of six groups, and software gives every group one of four priority levels, so all members of a group share a level. Each source keeps a sticky pending flag. A flag takes part in arbitration only when its own enable bit and the global enable are both set. The controller presents the winning source as a vector index together with its level. It tracks nested service, so a request may interrupt a handler that is already running only when its level is strictly higher.

The CPU acknowledges a presented vector, which clears that source's flag and records the level as in service. A return strobe retires the innermost level and restores the one beneath it. Two wake outputs serve the power controller. One wakes the CPU from idle whenever an interrupt would be presented. The other wakes it from sleep when a source that is allowed to do so, chosen by a parameter mask, is pending and enabled. Request lines pass through a synchronizer, so a pulse as short as one clock cycle is captured.

Top module: `gpic_top`

## Requirements
- R1: Source s belongs to group s mod 6. The level of group g is read from `grp_lvl[2g+1:2g]`, and 3 is the highest level.
- R2: A request sets the source's pending flag SYNC_STAGES+1 clock edges after it is sampled high (3 edges by default). The flag holds until `flag_clr` or an accepted acknowledge clears it. A set in the same cycle as a clear wins, and enables do not affect the flag.
- R3: `irq_out` is asserted only for a source whose flag and `src_en` bit are set while `glob_en` is high. A masked source stays pending and is not presented.
- R4: Among eligible sources, the group with the highest level wins. When several groups share that level, the lowest group index wins.
- R5: Within the winning group, the eligible source with the lowest index is presented on `irq_vec`.
- R6: `irq_ack` while `irq_out` is high clears the presented source's flag and marks its level in service from the next cycle (`svc_active`=1, `svc_lvl`=level). `irq_ack` while `irq_out` is low has no effect.
- R7: While a level is in service, `irq_out` is asserted only if the best eligible level is strictly higher. A request at an equal or lower level waits.
- R8: `irq_ret` retires the highest in-service level and restores the previous one. `irq_ret` with nothing in service has no effect. When a return and an accepted acknowledge arrive in the same cycle, the return is applied first.
- R9: `wake_idle` is high exactly when `cpu_idle` is high and `irq_out` is high.
- R10: `wake_sleep` is high when `cpu_sleep` and `glob_en` are high and some source that is pending, enabled and set in the SLEEP_WAKE mask exists (default mask: sources 0, 4, 5, 14). The in-service level plays no part in this output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 15 | Raw request lines, one per source |
| src_en | input | 15 | Per-source enable |
| glob_en | input | 1 | Global enable |
| grp_lvl | input | 12 | Two-bit level per group, group g at bits 2g+1:2g |
| flag_clr | input | 15 | Per-source pending-flag clear strobe |
| irq_ack | input | 1 | CPU accepts the presented vector |
| irq_ret | input | 1 | CPU returns from the innermost handler |
| cpu_idle | input | 1 | CPU is in idle mode |
| cpu_sleep | input | 1 | Device is in sleep mode |
| pend_flags | output | 15 | Pending flags |
| irq_out | output | 1 | Interrupt presented to the CPU |
| irq_vec | output | 4 | Index of the presented source |
| irq_lvl | output | 2 | Level of the presented source |
| svc_active | output | 1 | Some level is in service |
| svc_lvl | output | 2 | Innermost level in service |
| wake_idle | output | 1 | Wake request out of idle |
| wake_sleep | output | 1 | Wake request out of sleep |

## Verification
Directed sequences raise several sources across groups that share the top level and within one group, which separates the group tie rule from the source tie rule. The same sequences toggle the global and per-source enables, which separates masking from flag storage. A nested pattern enters a level, holds an equal-level request back, pre-empts it with a higher level, and unwinds through two returns plus a surplus one. This shows strict pre-emption and stack restoration apart from plain ordering. Constrained-random traffic then mixes sparse request bursts, level rewrites, clears, acknowledges and returns against a bench model, so that ordering, nesting and the wake outputs all interact.

// File: rtl/gpic_pkg.sv
package gpic_pkg;

    localparam int DEF_N_SRC = 15;
    localparam int DEF_N_GRP = 6;
    localparam int DEF_LVL_W = 2;

    // in-service stack operation for one cycle
    typedef enum logic [1:0] {
        SVC_HOLD = 2'd0,
        SVC_PUSH = 2'd1,
        SVC_POP  = 2'd2,
        SVC_SWAP = 2'd3
    } svc_op_e;

    // group membership of a source: round-robin over groups
    function automatic int grp_of(input int src, input int n_grp);
        return src % n_grp;
    endfunction

endpackage

// File: rtl/gpic_sync.sv
module gpic_sync #(
    parameter int W      = 15,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign d_out = d_in;
        end else begin : g_chain
            logic [W-1:0] stage_q [STAGES];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
                end else begin
                    stage_q[0] <= d_in;
                    for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
                end
            end
            assign d_out = stage_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/gpic_pend_bank.sv
module gpic_pend_bank #(
    parameter int N_SRC = 15,
    parameter int VEC_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] set_vec,
    input  logic [N_SRC-1:0] clr_vec,
    input  logic             take,
    input  logic [VEC_W-1:0] take_src,
    output logic [N_SRC-1:0] pend
);

    generate
        for (genvar s = 0; s < N_SRC; s++) begin : g_flag
            logic flag_q;
            logic taken;
            assign taken = take && (take_src == VEC_W'(s));
            always_ff @(posedge clk) begin
                if (rst) flag_q <= 1'b0;
                else     flag_q <= set_vec[s] | (flag_q & ~clr_vec[s] & ~taken);
            end
            assign pend[s] = flag_q;
        end
    endgenerate

endmodule

// File: rtl/gpic_arbiter.sv
module gpic_arbiter
    import gpic_pkg::*;
#(
    parameter int N_SRC = 15,
    parameter int N_GRP = 6,
    parameter int LVL_W = 2,
    parameter int VEC_W = 4
) (
    input  logic                   glob_en,
    input  logic [N_SRC-1:0]       pend,
    input  logic [N_SRC-1:0]       src_en,
    input  logic [N_GRP*LVL_W-1:0] grp_lvl,
    output logic                   hit,
    output logic [VEC_W-1:0]       win_src,
    output logic [LVL_W-1:0]       win_lvl
);

    logic [N_SRC-1:0] cand;
    logic [N_GRP-1:0] g_hit;
    logic [VEC_W-1:0] g_src [N_GRP];

    assign cand = pend & src_en & {N_SRC{glob_en}};

    // per group: lowest-index eligible member
    generate
        for (genvar g = 0; g < N_GRP; g++) begin : g_grp
            logic             any_l;
            logic [VEC_W-1:0] src_l;
            always_comb begin
                any_l = 1'b0;
                src_l = '0;
                for (int s = N_SRC - 1; s >= 0; s--) begin
                    if (grp_of(s, N_GRP) == g && cand[s]) begin
                        any_l = 1'b1;
                        src_l = VEC_W'(s);
                    end
                end
            end
            assign g_hit[g] = any_l;
            assign g_src[g] = src_l;
        end
    endgenerate

    // across groups: highest level, lower index overrides on equal level
    always_comb begin
        logic [LVL_W-1:0] lv;
        hit     = 1'b0;
        win_src = '0;
        win_lvl = '0;
        for (int g = N_GRP - 1; g >= 0; g--) begin
            lv = grp_lvl[g*LVL_W +: LVL_W];
            if (g_hit[g] && (!hit || lv >= win_lvl)) begin
                hit     = 1'b1;
                win_src = g_src[g];
                win_lvl = lv;
            end
        end
    end

endmodule

// File: rtl/gpic_svc_track.sv
module gpic_svc_track
    import gpic_pkg::*;
#(
    parameter int LVL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [LVL_W-1:0] push_lvl,
    input  logic             pop,
    output logic             active,
    output logic [LVL_W-1:0] top_lvl
);

    localparam int N_LVL = 1 << LVL_W;

    logic [N_LVL-1:0] insvc_q;
    logic [N_LVL-1:0] insvc_d;
    logic [N_LVL-1:0] push_bit;
    logic [N_LVL-1:0] top_bit;
    svc_op_e          op;

    // strictly rising nesting makes the stack equivalent to a level bitmap
    always_comb begin
        top_lvl = '0;
        for (int i = 0; i < N_LVL; i++) begin
            if (insvc_q[i]) top_lvl = LVL_W'(i);
        end
    end

    assign active   = |insvc_q;
    assign push_bit = N_LVL'(1) << push_lvl;
    assign top_bit  = N_LVL'(1) << top_lvl;

    always_comb begin
        unique case ({push, pop && active})
            2'b10:   op = SVC_PUSH;
            2'b01:   op = SVC_POP;
            2'b11:   op = SVC_SWAP;
            default: op = SVC_HOLD;
        endcase
    end

    always_comb begin
        unique case (op)
            SVC_PUSH: insvc_d = insvc_q | push_bit;
            SVC_POP:  insvc_d = insvc_q & ~top_bit;
            SVC_SWAP: insvc_d = (insvc_q & ~top_bit) | push_bit;
            default:  insvc_d = insvc_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) insvc_q <= '0;
        else     insvc_q <= insvc_d;
    end

endmodule

// File: rtl/gpic_top.sv
module gpic_top
    import gpic_pkg::*;
#(
    parameter int                     N_SRC       = DEF_N_SRC,
    parameter int                     N_GRP       = DEF_N_GRP,
    parameter int                     LVL_W       = DEF_LVL_W,
    parameter int                     SYNC_STAGES = 2,
    parameter logic [DEF_N_SRC-1:0]   SLEEP_WAKE  = 15'h4031,
    localparam int                    VEC_W       = $clog2(N_SRC)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_SRC-1:0]       irq_req,
    input  logic [N_SRC-1:0]       src_en,
    input  logic                   glob_en,
    input  logic [N_GRP*LVL_W-1:0] grp_lvl,
    input  logic [N_SRC-1:0]       flag_clr,
    input  logic                   irq_ack,
    input  logic                   irq_ret,
    input  logic                   cpu_idle,
    input  logic                   cpu_sleep,
    output logic [N_SRC-1:0]       pend_flags,
    output logic                   irq_out,
    output logic [VEC_W-1:0]       irq_vec,
    output logic [LVL_W-1:0]       irq_lvl,
    output logic                   svc_active,
    output logic [LVL_W-1:0]       svc_lvl,
    output logic                   wake_idle,
    output logic                   wake_sleep
);

    logic [N_SRC-1:0] req_s;
    logic             pick_hit;
    logic [VEC_W-1:0] pick_src;
    logic [LVL_W-1:0] pick_lvl;
    logic             grant;
    logic             take;

    gpic_sync #(.W(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (irq_req),
        .d_out (req_s)
    );

    gpic_pend_bank #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (req_s),
        .clr_vec  (flag_clr),
        .take     (take),
        .take_src (pick_src),
        .pend     (pend_flags)
    );

    gpic_arbiter #(.N_SRC(N_SRC), .N_GRP(N_GRP), .LVL_W(LVL_W), .VEC_W(VEC_W)) u_arb (
        .glob_en (glob_en),
        .pend    (pend_flags),
        .src_en  (src_en),
        .grp_lvl (grp_lvl),
        .hit     (pick_hit),
        .win_src (pick_src),
        .win_lvl (pick_lvl)
    );

    gpic_svc_track #(.LVL_W(LVL_W)) u_svc (
        .clk      (clk),
        .rst      (rst),
        .push     (take),
        .push_lvl (pick_lvl),
        .pop      (irq_ret),
        .active   (svc_active),
        .top_lvl  (svc_lvl)
    );

    // strict pre-emption against the innermost level in service
    assign grant = pick_hit && (!svc_active || pick_lvl > svc_lvl);
    assign take  = irq_ack && grant;

    assign irq_out    = grant;
    assign irq_vec    = pick_src;
    assign irq_lvl    = pick_lvl;
    assign wake_idle  = cpu_idle && grant;
    assign wake_sleep = cpu_sleep && glob_en && |(pend_flags & src_en & SLEEP_WAKE[N_SRC-1:0]);

endmodule

// File: rtl/gpic_checker.sv
module gpic_checker #(
    parameter int N_SRC = 15,
    parameter int LVL_W = 2,
    localparam int VEC_W = $clog2(N_SRC)
) (
    input logic             clk,
    input logic             rst,
    input logic [N_SRC-1:0] src_en,
    input logic             glob_en,
    input logic             irq_ack,
    input logic             cpu_idle,
    input logic             cpu_sleep,
    input logic [N_SRC-1:0] pend_flags,
    input logic             irq_out,
    input logic [VEC_W-1:0] irq_vec,
    input logic [LVL_W-1:0] irq_lvl,
    input logic             svc_active,
    input logic [LVL_W-1:0] svc_lvl,
    input logic             wake_idle,
    input logic             wake_sleep
);

    p_gate_off_r3: assert property (@(posedge clk) disable iff (rst)
        !glob_en |-> !irq_out);

    p_vec_eligible_r3: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (src_en[irq_vec] && pend_flags[irq_vec]));

    p_ack_enters_r6: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && irq_out) |=> (svc_active && svc_lvl == $past(irq_lvl)));

    p_preempt_strict_r7: assert property (@(posedge clk) disable iff (rst)
        (irq_out && svc_active) |-> (irq_lvl > svc_lvl));

    p_idle_stays_r8: assert property (@(posedge clk) disable iff (rst)
        (!svc_active && !irq_ack) |=> !svc_active);

    p_wake_idle_r9: assert property (@(posedge clk) disable iff (rst)
        wake_idle == (cpu_idle && irq_out));

    p_sleep_gate_r10: assert property (@(posedge clk) disable iff (rst)
        (!cpu_sleep || !glob_en) |-> !wake_sleep);

endmodule

bind gpic_top gpic_checker #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .src_en     (src_en),
    .glob_en    (glob_en),
    .irq_ack    (irq_ack),
    .cpu_idle   (cpu_idle),
    .cpu_sleep  (cpu_sleep),
    .pend_flags (pend_flags),
    .irq_out    (irq_out),
    .irq_vec    (irq_vec),
    .irq_lvl    (irq_lvl),
    .svc_active (svc_active),
    .svc_lvl    (svc_lvl),
    .wake_idle  (wake_idle),
    .wake_sleep (wake_sleep)
);

// File: tb/gpic_top_tb.sv
`timescale 1ns/1ps
module gpic_top_tb;

    localparam int          NS    = 15;
    localparam int          NG    = 6;
    localparam logic [14:0] SLEEP = 15'h4031;
    localparam logic [14:0] ALL   = 15'h7FFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] irq_req = '0, src_en = '0, flag_clr = '0;
    logic        glob_en = 1'b0, irq_ack = 1'b0, irq_ret = 1'b0;
    logic        cpu_idle = 1'b0, cpu_sleep = 1'b0;
    logic [11:0] grp_lvl = '0;
    logic [14:0] pend_flags;
    logic        irq_out, svc_active, wake_idle, wake_sleep;
    logic [3:0]  irq_vec;
    logic [1:0]  irq_lvl, svc_lvl;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    // bench model state
    logic [14:0] m_s0 = '0, m_s1 = '0, m_pend = '0;
    logic [3:0]  m_ins = '0;

    always #5 clk = ~clk;

    gpic_top #(.SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .irq_req(irq_req), .src_en(src_en),
        .glob_en(glob_en), .grp_lvl(grp_lvl), .flag_clr(flag_clr),
        .irq_ack(irq_ack), .irq_ret(irq_ret), .cpu_idle(cpu_idle),
        .cpu_sleep(cpu_sleep), .pend_flags(pend_flags), .irq_out(irq_out),
        .irq_vec(irq_vec), .irq_lvl(irq_lvl), .svc_active(svc_active),
        .svc_lvl(svc_lvl), .wake_idle(wake_idle), .wake_sleep(wake_sleep)
    );

    // {hit, vec[3:0], lvl[1:0]} from the ordering rules R1, R4, R5
    function automatic logic [6:0] ref_pick(input logic [14:0] p, input logic [14:0] e,
                                            input logic g, input logic [11:0] lv);
        int best_g = -1;
        int best_s = 0;
        int best_l = 0;
        for (int gg = 0; gg < NG; gg++) begin
            int found = -1;
            for (int s = 0; s < NS; s++)
                if (found < 0 && (s % NG) == gg && p[s] && e[s] && g) found = s;
            if (found >= 0 && (best_g < 0 || int'(lv[gg*2 +: 2]) > best_l)) begin
                best_g = gg;
                best_s = found;
                best_l = int'(lv[gg*2 +: 2]);
            end
        end
        return {best_g >= 0, 4'(best_s), 2'(best_l)};
    endfunction

    function automatic int ref_top(input logic [3:0] ins);
        int t = -1;
        for (int i = 0; i < 4; i++) if (ins[i]) t = i;
        return t;
    endfunction

    function automatic logic ref_grant(input logic [6:0] pk, input logic [3:0] ins);
        return pk[6] && (ref_top(ins) < 0 || int'(pk[1:0]) > ref_top(ins));
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic model_cmp();
        logic [6:0] pk;
        logic       gr;
        pk = ref_pick(m_pend, src_en, glob_en, grp_lvl);
        gr = ref_grant(pk, m_ins);
        chk("R2 model pend", 32'(pend_flags), 32'(m_pend));
        chk("R7 model irq_out", 32'(irq_out), 32'(gr));
        if (gr) begin
            chk("R4 model irq_vec", 32'(irq_vec), 32'(pk[5:2]));
            chk("R4 model irq_lvl", 32'(irq_lvl), 32'(pk[1:0]));
        end
        chk("R8 model svc_active", 32'(svc_active), 32'(m_ins != 0));
        if (m_ins != 0) chk("R8 model svc_lvl", 32'(svc_lvl), 32'(ref_top(m_ins)));
        chk("R9 model wake_idle", 32'(wake_idle), 32'(cpu_idle && gr));
        chk("R10 model wake_sleep", 32'(wake_sleep),
            32'(cpu_sleep && glob_en && |(m_pend & src_en & SLEEP)));
    endtask

    task automatic tick();
        logic [6:0] pk;
        logic       gr;
        @(posedge clk);
        if (rst) begin
            m_s0 = '0; m_s1 = '0; m_pend = '0; m_ins = '0;
        end else begin
            pk = ref_pick(m_pend, src_en, glob_en, grp_lvl);
            gr = ref_grant(pk, m_ins);
            m_pend = (m_pend & ~flag_clr & ~((irq_ack && gr) ? (15'd1 << pk[5:2]) : 15'd0)) | m_s1;
            m_s1 = m_s0;
            m_s0 = irq_req;
            if (irq_ret && m_ins != 0) m_ins[ref_top(m_ins)] = 1'b0;
            if (irq_ack && gr) m_ins[pk[1:0]] = 1'b1;
        end
        @(negedge clk);
        if (!rst) model_cmp();
    endtask

    task automatic pulse(input logic [14:0] r);
        irq_req = r;
        tick();
        irq_req = '0;
        tick();
        tick();
    endtask

    initial begin
        #1ms;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // reset state
        chk("R2 reset pend", 32'(pend_flags), 0);
        chk("R6 reset svc_active", 32'(svc_active), 0);
        chk("R3 reset irq_out", 32'(irq_out), 0);

        // levels: g0=1, g1=3, g2=3, others 0
        grp_lvl = 12'h03D;
        src_en  = ALL;
        glob_en = 1'b1;
        pulse(15'h0007);
        chk("R2 flags set", 32'(pend_flags), 32'h7);
        chk("R4 group tie lowest index", 32'(irq_vec), 1);
        chk("R4 winning level", 32'(irq_lvl), 3);

        flag_clr = ALL; tick(); flag_clr = '0;
        chk("R2 clear", 32'(pend_flags), 0);
        pulse(15'h4140);
        chk("R5 lowest source in group", 32'(irq_vec), 8);
        chk("R1 source 14 in group 2", 32'(irq_lvl), 3);

        glob_en = 1'b0; tick();
        chk("R3 global mask", 32'(irq_out), 0);
        chk("R3 flags kept", 32'(pend_flags), 32'h4140);
        glob_en = 1'b1; src_en = ALL & ~15'h0100; tick();
        chk("R3 source mask", 32'(irq_vec), 14);

        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
        chk("R6 flag taken", 32'(pend_flags), 32'h0140);
        chk("R6 svc level", 32'(svc_lvl), 3);
        chk("R7 lower level waits", 32'(irq_out), 0);

        irq_ret = 1'b1; tick(); irq_ret = 1'b0;
        chk("R8 returned", 32'(svc_active), 0);
        chk("R8 next vector", 32'(irq_vec), 6);

        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
        chk("R6 svc level 1", 32'(svc_lvl), 1);
        pulse(15'h1000);
        chk("R7 equal level waits", 32'(irq_out), 0);
        pulse(15'h0002);
        chk("R7 higher pre-empts", 32'(irq_out), 1);
        chk("R7 pre-empt vector", 32'(irq_vec), 1);
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
        chk("R6 nested level", 32'(svc_lvl), 3);
        irq_ret = 1'b1; tick(); irq_ret = 1'b0;
        chk("R8 restored level", 32'(svc_lvl), 1);
        chk("R8 still active", 32'(svc_active), 1);
        irq_ret = 1'b1; tick();
        chk("R8 stack empty", 32'(svc_active), 0);
        chk("R8 waiting vector", 32'(irq_vec), 12);
        tick(); irq_ret = 1'b0;
        chk("R8 surplus return ignored", 32'(svc_active), 0);

        glob_en = 1'b0; irq_ack = 1'b1; tick(); irq_ack = 1'b0;
        chk("R6 ack without irq ignored", 32'(svc_active), 0);
        chk("R6 flags untouched", 32'(pend_flags), 32'h1100);
        glob_en = 1'b1;

        flag_clr = ALL; tick(); flag_clr = '0;
        cpu_sleep = 1'b1; cpu_idle = 1'b1;
        pulse(15'h0008);
        chk("R10 non-waking source", 32'(wake_sleep), 0);
        chk("R9 idle wake", 32'(wake_idle), 1);
        pulse(15'h0010);
        chk("R10 waking source", 32'(wake_sleep), 1);
        cpu_idle = 1'b0; tick();
        chk("R9 not idle", 32'(wake_idle), 0);
        cpu_sleep = 1'b0;

        flag_clr = ALL; tick();
        irq_req = 15'h0020;
        repeat (4) tick();
        chk("R2 set beats clear", 32'(pend_flags), 32'h0020);
        irq_req = '0;
        repeat (3) tick();
        chk("R2 cleared after drop", 32'(pend_flags), 0);
        flag_clr = '0;

        for (int k = 0; k < 3000; k++) begin
            irq_req   = 15'($urandom & $urandom & $urandom);
            src_en    = 15'(~($urandom & $urandom & $urandom));
            glob_en   = ($urandom % 16) != 0;
            if ($urandom % 32 == 0) grp_lvl = 12'($urandom);
            flag_clr  = ($urandom % 8 == 0) ? 15'($urandom & $urandom) : 15'd0;
            irq_ack   = ($urandom % 3) == 0;
            irq_ret   = ($urandom % 5) == 0;
            cpu_idle  = $urandom % 2;
            cpu_sleep = $urandom % 2;
            tick();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule